// File: doc/BRIEF.md
# Instruction Dispatch Classifier

This block sits between the rename stage and the out-of-order back end. Each cycle it receives a bundle of up to `N` renamed instructions, each carrying a set of flags: squashed, load, store, non-speculative and nop. It walks the slots from the lowest index upward and chooses one destination for each slot. A slot can be dropped as squashed, sent to the issue queue, sent to the issue queue together with a load-queue or store-queue reservation, placed on a separate non-speculative insert path, or completed on the spot as a nop.

The queues themselves live outside the block. The caller supplies the number of free issue-queue entries for this cycle. The block returns one insert strobe per slot for each destination. If the issue queue runs out of entries part way through a bundle, the walk stops at the slot that found no room. The block then raises a stall towards the upstream stage and reports how many slots it consumed. The upstream stage or a skid buffer keeps the slots that were not consumed and presents them again later.

Running tallies of each category are kept in registers. They let the surrounding pipeline measure dispatch behaviour.

Top module: `dispatch_classifier`

## Requirements
- R1: Only slots whose index is below `slot_cnt` are examined, in ascending index order. A count above `N` is treated as `N`. Slots at or above the count raise no strobe. For every vector, bit i belongs to slot i.
- R2: A squashed slot raises no strobe of any kind and uses no issue-queue entry. It adds one to `tally_squash`. The full condition is not tested for it, so it is consumed even when the issue queue has no room.
- R3: When a non-squashed slot is reached and the entries used earlier in this cycle equal `iq_free`, the walk stops at that slot. The block then raises `stall_up`, sets `taken_cnt` to that slot's index and raises no strobe for that slot or any later slot. `tally_full` goes up by one.
- R4: A load slot raises `lq_push` and `iq_push` and uses one issue-queue entry.
- R5: A store slot raises `sq_push` and `iq_push` and uses one issue-queue entry.
- R6: A non-speculative slot raises `ns_push` and `commit_mark`, does not raise `iq_push`, and uses one issue-queue entry.
- R7: A nop slot raises `nop_retire` and `commit_mark` and uses no issue-queue entry. It still stops the walk when the queue is full.
- R8: When several flags are set on one slot, they take effect in this order: squashed, then queue full, then load, then store, then non-speculative, then nop. A slot with none of these flags raises `iq_push` only.
- R9: If the walk does not stop, `taken_cnt` equals the effective bundle size and `stall_up` is low.
- R10: All tallies reset to zero. At each clock edge they add that cycle's counts: squashed skips, stops on a full queue, `iq_push` strobes, loads, stores, non-speculative inserts and nops.
- R11: The issue-queue entries used in one cycle, counted over `iq_push` and `ns_push`, never exceed `iq_free`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the tallies |
| slot_cnt | input | $clog2(N+1) | Number of occupied slots in the bundle |
| iq_free | input | $clog2(IQ_DEPTH+1) | Free issue-queue entries this cycle |
| is_squashed | input | N | Per-slot squashed flag |
| is_load | input | N | Per-slot load flag |
| is_store | input | N | Per-slot store flag |
| is_nonspec | input | N | Per-slot non-speculative flag |
| is_nop | input | N | Per-slot nop flag |
| iq_push | output | N | Issue-queue insert strobe per slot |
| lq_push | output | N | Load-queue reservation strobe per slot |
| sq_push | output | N | Store-queue reservation strobe per slot |
| ns_push | output | N | Non-speculative insert strobe per slot |
| nop_retire | output | N | Nop marked issued, executed and completed |
| commit_mark | output | N | Slot marked ready to commit |
| taken_cnt | output | $clog2(N+1) | Slots consumed this cycle |
| stall_up | output | 1 | Block and stall request to the upstream stage |
| tally_squash | output | CNT_W | Squashed slots skipped |
| tally_full | output | CNT_W | Stops caused by a full issue queue |
| tally_iq | output | CNT_W | Issue-queue inserts |
| tally_load | output | CNT_W | Loads dispatched |
| tally_store | output | CNT_W | Stores dispatched |
| tally_nonspec | output | CNT_W | Non-speculative inserts |
| tally_nop | output | CNT_W | Nops completed in place |

## Verification
Two things can happen in the same cycle: squashed slots are skipped and the walk stops on a full queue. They interact because the skip is decided before the full test. The bench provokes this with a bundle that starts with squashed slots and is followed by an ordinary slot while `iq_free` is zero. It expects the squashed slots to be consumed and the stop to land on the first ordinary slot. A second case pairs a nop with a queue that one earlier insert has just filled. There the stop must win over the nop, even though the nop needs no entry. Each of these cycles is judged both on the same-cycle strobes and `taken_cnt`, and on the tally values after the following clock edge.

// File: rtl/dispatch_classifier.sv
module dispatch_classifier #(
  parameter int N        = 4,
  parameter int IQ_DEPTH = 16,
  parameter int CNT_W    = 16,
  localparam int CW = $clog2(N + 1),
  localparam int FW = $clog2(IQ_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    slot_cnt,
  input  logic [FW-1:0]    iq_free,
  input  logic [N-1:0]     is_squashed,
  input  logic [N-1:0]     is_load,
  input  logic [N-1:0]     is_store,
  input  logic [N-1:0]     is_nonspec,
  input  logic [N-1:0]     is_nop,
  output logic [N-1:0]     iq_push,
  output logic [N-1:0]     lq_push,
  output logic [N-1:0]     sq_push,
  output logic [N-1:0]     ns_push,
  output logic [N-1:0]     nop_retire,
  output logic [N-1:0]     commit_mark,
  output logic [CW-1:0]    taken_cnt,
  output logic             stall_up,
  output logic [CNT_W-1:0] tally_squash,
  output logic [CNT_W-1:0] tally_full,
  output logic [CNT_W-1:0] tally_iq,
  output logic [CNT_W-1:0] tally_load,
  output logic [CNT_W-1:0] tally_store,
  output logic [CNT_W-1:0] tally_nonspec,
  output logic [CNT_W-1:0] tally_nop
);

  logic [N-1:0]  skipped;
  logic [FW-1:0] used;
  logic [CW-1:0] lim;
  logic          halt;

  assign lim = (int'(slot_cnt) > N) ? CW'(N) : slot_cnt;

  always_comb begin
    iq_push     = '0;
    lq_push     = '0;
    sq_push     = '0;
    ns_push     = '0;
    nop_retire  = '0;
    commit_mark = '0;
    skipped     = '0;
    used        = '0;
    halt        = 1'b0;
    taken_cnt   = lim;
    for (int i = 0; i < N; i++) begin
      if (i < int'(lim) && !halt) begin
        if (is_squashed[i]) begin
          skipped[i] = 1'b1;
        end else if (used >= iq_free) begin
          halt      = 1'b1;
          taken_cnt = CW'(i);
        end else if (is_load[i]) begin
          lq_push[i] = 1'b1;
          iq_push[i] = 1'b1;
          used       = used + FW'(1);
        end else if (is_store[i]) begin
          sq_push[i] = 1'b1;
          iq_push[i] = 1'b1;
          used       = used + FW'(1);
        end else if (is_nonspec[i]) begin
          ns_push[i]     = 1'b1;
          commit_mark[i] = 1'b1;
          used           = used + FW'(1);
        end else if (is_nop[i]) begin
          nop_retire[i]  = 1'b1;
          commit_mark[i] = 1'b1;
        end else begin
          iq_push[i] = 1'b1;
          used       = used + FW'(1);
        end
      end
    end
  end

  assign stall_up = halt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tally_squash  <= '0;
      tally_full    <= '0;
      tally_iq      <= '0;
      tally_load    <= '0;
      tally_store   <= '0;
      tally_nonspec <= '0;
      tally_nop     <= '0;
    end else begin
      tally_squash  <= tally_squash  + CNT_W'($countones(skipped));
      tally_full    <= tally_full    + CNT_W'(halt);
      tally_iq      <= tally_iq      + CNT_W'($countones(iq_push));
      tally_load    <= tally_load    + CNT_W'($countones(lq_push));
      tally_store   <= tally_store   + CNT_W'($countones(sq_push));
      tally_nonspec <= tally_nonspec + CNT_W'($countones(ns_push));
      tally_nop     <= tally_nop     + CNT_W'($countones(nop_retire));
    end
  end

endmodule

module dispatch_classifier_chk #(
  parameter int N        = 4,
  parameter int IQ_DEPTH = 16,
  parameter int CNT_W    = 16,
  localparam int CW = $clog2(N + 1),
  localparam int FW = $clog2(IQ_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CW-1:0]    slot_cnt,
  input logic [FW-1:0]    iq_free,
  input logic [N-1:0]     is_squashed,
  input logic [N-1:0]     is_load,
  input logic [N-1:0]     is_store,
  input logic [N-1:0]     is_nonspec,
  input logic [N-1:0]     is_nop,
  input logic [N-1:0]     iq_push,
  input logic [N-1:0]     lq_push,
  input logic [N-1:0]     sq_push,
  input logic [N-1:0]     ns_push,
  input logic [N-1:0]     nop_retire,
  input logic [N-1:0]     commit_mark,
  input logic [CW-1:0]    taken_cnt,
  input logic             stall_up,
  input logic [CNT_W-1:0] tally_squash,
  input logic [CNT_W-1:0] tally_full,
  input logic [CNT_W-1:0] tally_iq,
  input logic [CNT_W-1:0] tally_load,
  input logic [CNT_W-1:0] tally_store,
  input logic [CNT_W-1:0] tally_nonspec,
  input logic [CNT_W-1:0] tally_nop
);

  logic [N-1:0] any_push;
  assign any_push = iq_push | lq_push | sq_push | ns_push | nop_retire | commit_mark;

  assert_beyond_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (any_push >> taken_cnt) == '0);

  assert_squash_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (any_push & is_squashed) == '0);

  assert_stop_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_up |-> (taken_cnt < slot_cnt));

  assert_full_tally_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall_up |=> tally_full == $past(tally_full) + CNT_W'(1));

  assert_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iq_push | ns_push) <= int'(iq_free));

  for (genvar g = 0; g < N; g++) begin : g_slot
    assert_one_dest_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({iq_push[g], ns_push[g], nop_retire[g]}));
    assert_lq_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lq_push[g] |-> (iq_push[g] && !sq_push[g]));
    assert_sq_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sq_push[g] |-> iq_push[g]);
    assert_ns_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ns_push[g] |-> commit_mark[g]);
    assert_nop_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
      nop_retire[g] |-> commit_mark[g]);
  end

endmodule

bind dispatch_classifier dispatch_classifier_chk #(
  .N(N), .IQ_DEPTH(IQ_DEPTH), .CNT_W(CNT_W)
) chk (.*);

// File: tb/dispatch_classifier_test.sv
module dispatch_classifier_test;
  localparam int N = 4;
  localparam int IQ_DEPTH = 16;
  localparam int CNT_W = 16;
  localparam int CW = $clog2(N + 1);
  localparam int FW = $clog2(IQ_DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] slot_cnt = '0;
  logic [FW-1:0] iq_free = '0;
  logic [N-1:0] is_squashed = '0, is_load = '0, is_store = '0, is_nonspec = '0, is_nop = '0;
  logic [N-1:0] iq_push, lq_push, sq_push, ns_push, nop_retire, commit_mark;
  logic [CW-1:0] taken_cnt;
  logic stall_up;
  logic [CNT_W-1:0] tally_squash, tally_full, tally_iq, tally_load, tally_store, tally_nonspec, tally_nop;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dispatch_classifier #(.N(N), .IQ_DEPTH(IQ_DEPTH), .CNT_W(CNT_W)) uut (.*);

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(int sz, int fr, logic [N-1:0] s, logic [N-1:0] l, logic [N-1:0] st,
                       logic [N-1:0] ns, logic [N-1:0] np);
    @(negedge clk);
    slot_cnt = CW'(sz); iq_free = FW'(fr);
    is_squashed = s; is_load = l; is_store = st; is_nonspec = ns; is_nop = np;
    #1;
  endtask

  task automatic expect_out(string tag, logic [N-1:0] iq, logic [N-1:0] lq, logic [N-1:0] sq,
                            logic [N-1:0] ns, logic [N-1:0] np, logic [N-1:0] cm, int tk, int stl);
    chk({tag, " iq_push"}, int'(iq_push), int'(iq));
    chk({tag, " lq_push"}, int'(lq_push), int'(lq));
    chk({tag, " sq_push"}, int'(sq_push), int'(sq));
    chk({tag, " ns_push"}, int'(ns_push), int'(ns));
    chk({tag, " nop_retire"}, int'(nop_retire), int'(np));
    chk({tag, " commit_mark"}, int'(commit_mark), int'(cm));
    chk({tag, " taken_cnt"}, int'(taken_cnt), tk);
    chk({tag, " stall_up"}, int'(stall_up), stl);
  endtask

  task automatic expect_tallies(string tag, int sq, int fu, int iq, int ld, int st, int ns, int np);
    chk({tag, " tally_squash"}, int'(tally_squash), sq);
    chk({tag, " tally_full"}, int'(tally_full), fu);
    chk({tag, " tally_iq"}, int'(tally_iq), iq);
    chk({tag, " tally_load"}, int'(tally_load), ld);
    chk({tag, " tally_store"}, int'(tally_store), st);
    chk({tag, " tally_nonspec"}, int'(tally_nonspec), ns);
    chk({tag, " tally_nop"}, int'(tally_nop), np);
  endtask

  task automatic t_reset;
    drive(0, 16, '0, '0, '0, '0, '0);
    expect_tallies("R10 reset", 0, 0, 0, 0, 0, 0, 0);
    expect_out("R1 empty bundle", '0, '0, '0, '0, '0, '0, 0, 0);
  endtask

  task automatic t_plain_full_bundle;
    drive(4, 16, '0, '0, '0, '0, '0);
    expect_out("R9 four plain", 4'b1111, '0, '0, '0, '0, '0, 4, 0);
  endtask

  task automatic t_short_bundle;
    drive(2, 16, '0, '0, '0, '0, '0);
    expect_out("R1 size two", 4'b0011, '0, '0, '0, '0, '0, 2, 0);
  endtask

  task automatic t_mem_mix;
    drive(4, 16, '0, 4'b0101, 4'b1010, '0, '0);
    expect_out("R4 R5 loads stores", 4'b1111, 4'b0101, 4'b1010, '0, '0, '0, 4, 0);
  endtask

  task automatic t_priority;
    drive(4, 16, '0, 4'b0001, 4'b0011, 4'b0111, 4'b1101);
    expect_out("R8 R6 R7 priority", 4'b0011, 4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b1100, 4, 0);
  endtask

  task automatic t_full_mid;
    drive(4, 2, '0, '0, '0, '0, '0);
    expect_out("R3 R11 stop at slot2", 4'b0011, '0, '0, '0, '0, '0, 2, 1);
  endtask

  task automatic t_squash_when_full;
    drive(3, 0, 4'b0011, '0, '0, '0, '0);
    expect_out("R2 R3 squash then full", '0, '0, '0, '0, '0, '0, 2, 1);
  endtask

  task automatic t_nop_when_full;
    drive(2, 1, '0, '0, '0, '0, 4'b0010);
    expect_out("R7 R3 nop stops", 4'b0001, '0, '0, '0, '0, '0, 1, 1);
  endtask

  task automatic t_squashed_load;
    drive(1, 16, 4'b0001, 4'b0001, '0, '0, '0);
    expect_out("R2 squashed load", '0, '0, '0, '0, '0, '0, 1, 0);
  endtask

  task automatic t_final_tallies;
    drive(0, 16, '0, '0, '0, '0, '0);
    expect_tallies("R10 accumulated", 3, 3, 15, 3, 3, 1, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain_full_bundle();
    t_short_bundle();
    t_mem_mix();
    t_priority();
    t_full_mid();
    t_squash_when_full();
    t_nop_when_full();
    t_squashed_load();
    t_final_tallies();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule